// File: doc/BRIEF.md
# Residue-Checked Arithmetic Logic Unit

This block is a 32-bit ALU whose operands and result each carry a 16-bit check vector. The vector holds the word's residues modulo the odd numbers 5, 7, 17 and 31. The unit predicts the result's check vector from the operands' check vectors. It then encodes the result it actually computed and compares the two. Any mismatch clears a residue-valid flag that travels with the result.

Addition is the native operation of this code. An add predicts its residues by componentwise modular addition and completes in one cycle. AND, OR and XOR cannot be predicted from the operand residues alone. Each needs the residue of a helper word: the XOR of the operands for AND and OR, and the AND of the operands for XOR. The block has only one residue encoder, which it reuses over three cycles for these operations:

- first cycle: the helper word,
- second cycle: the result,
- third cycle: operand A.

Checking operand A catches error pairs that cancel in the sum of the two operand residues. While the three-cycle sequence runs, a busy output is high, and start requests are ignored.

Top module: `resid_alu`

## Requirements
- R1: Check vectors pack the residues as follows: bits [2:0] hold the value mod 5, [5:3] mod 7, [10:6] mod 17 and [15:11] mod 31. When both operand check vectors are consistent with their operands, y_res_o equals the residues of y_o and res_ok_o is 1.
- R2: Op code 0 (add) sets y_o to (a_i + b_i) mod 2^32 at the clock edge that samples start_i. busy_o stays low.
- R3: For an add whose true sum overflows 32 bits, each predicted residue is (pa + pb - (2^32 mod m)) mod m. A consistent wrapped add therefore still reports res_ok_o = 1.
- R4: Op code 1 (AND) sets y_o to a_i & b_i. Each predicted residue is (pa + pb - ((a XOR b) mod m)) / 2 mod m, where halving means multiplying by the inverse of 2 modulo m.
- R5: Op code 2 (OR) sets y_o to a_i | b_i. Each predicted residue is (pa + pb + ((a XOR b) mod m)) / 2 mod m.
- R6: Op code 3 (XOR) sets y_o to a_i ^ b_i. Each predicted residue is (pa + pb - 2·((a AND b) mod m)) mod m.
- R7: A Boolean operation raises busy_o for exactly the two cycles after its start edge. y_o, y_res_o and res_ok_o keep their old values until the third edge, when all three update together.
- R8: A start_i sampled while busy_o is high is ignored. Its operands and op code affect no output.
- R9: res_ok_o is 0 when the predicted check vector of the result differs from the encoding of y_o, for example when one operand's check vector is corrupted.
- R10: For a Boolean operation, res_ok_o is 0 when a_res_i does not encode a_i, even if the errors on the two operand vectors cancel in the result prediction.
- R11: While rst_n is low, y_o, y_res_o, busy_o and res_ok_o are all 0.
- R12: Without an accepted start, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to start an operation |
| op_i | input | 2 | 0 add, 1 AND, 2 OR, 3 XOR |
| a_i | input | 32 | Operand A |
| a_res_i | input | 16 | Check vector of operand A |
| b_i | input | 32 | Operand B |
| b_res_i | input | 16 | Check vector of operand B |
| y_o | output | 32 | Result word |
| y_res_o | output | 16 | Predicted check vector of the result |
| busy_o | output | 1 | High while a Boolean operation is in progress |
| res_ok_o | output | 1 | All residue checks of the last operation matched |

## Verification
Some internal faults show up in timing. A sequencer that loses or repeats a phase shows at the ports in the next cycle as a wrong busy_o level. It also shows as an update of y_o at the wrong edge.

Other faults show up in the check flag. Wrong latched residues, a stale helper residue, or a wrong halving constant appear at the completion edge. They clear res_ok_o for consistent operands, or leave it set for corrupted ones. The completion edge is the same edge for an add and two edges later for a Boolean operation.

The bench steps a behavioural model every clock and compares all four outputs on every cycle, so such a fault is caught within three cycles of the start it corrupts.

// File: rtl/rmalu_pkg.sv
`timescale 1ns/1ps
package rmalu_pkg;
   localparam int NMOD = 4;
   localparam int MODS [NMOD] = '{5, 7, 17, 31};

   typedef enum logic [1:0] {OP_ADD = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2, OP_XOR = 2'd3} op_e;
   typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RES = 2'd1, PH_OPD = 2'd2} phase_e;

   function automatic int fld_w(int i);
      return $clog2(MODS[i]);
   endfunction

   function automatic int fld_lo(int i);
      int s;
      s = 0;
      for (int k = 0; k < i; k++) s += $clog2(MODS[k]);
      return s;
   endfunction

   function automatic int pow2_mod(int w, int m);
      int r;
      r = 1;
      for (int k = 0; k < w; k++) r = (r * 2) % m;
      return r;
   endfunction

   localparam int RES_W = fld_lo(NMOD);
endpackage

// File: rtl/rmalu_encoder.sv
`timescale 1ns/1ps
module rmalu_encoder import rmalu_pkg::*; #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] val_i,
   output logic [RES_W-1:0]  res_o
);
   for (genvar i = 0; i < NMOD; i++) begin : g_fld
      localparam int M  = MODS[i];
      localparam int W  = fld_w(i);
      localparam int LO = fld_lo(i);
      assign res_o[LO +: W] = W'(val_i % DATA_W'(M));
   end
endmodule

// File: rtl/rmalu_logic.sv
`timescale 1ns/1ps
module rmalu_logic import rmalu_pkg::*; #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  op_e               op_i,
   output logic [DATA_W-1:0] y_o,
   output logic [DATA_W-1:0] aux_o,
   output logic              carry_o
);
   logic [DATA_W:0] sum;

   assign sum     = {1'b0, a_i} + {1'b0, b_i};
   assign carry_o = sum[DATA_W];
   // helper word whose residue feeds the prediction of a Boolean result
   assign aux_o   = (op_i == OP_XOR) ? (a_i & b_i) : (a_i ^ b_i);

   always_comb begin
      unique case (op_i)
         OP_ADD:  y_o = sum[DATA_W-1:0];
         OP_AND:  y_o = a_i & b_i;
         OP_OR:   y_o = a_i | b_i;
         default: y_o = a_i ^ b_i;
      endcase
   end
endmodule

// File: rtl/rmalu_predict.sv
`timescale 1ns/1ps
module rmalu_predict import rmalu_pkg::*; #(
   parameter int DATA_W = 32
) (
   input  op_e              op_i,
   input  logic [RES_W-1:0] pa_i,
   input  logic [RES_W-1:0] pb_i,
   input  logic [RES_W-1:0] aux_i,
   input  logic             carry_i,
   output logic [RES_W-1:0] res_o
);
   for (genvar i = 0; i < NMOD; i++) begin : g_fld
      localparam int M    = MODS[i];
      localparam int W    = fld_w(i);
      localparam int LO   = fld_lo(i);
      localparam int WRAP = pow2_mod(DATA_W, M);   // weight of the lost carry
      localparam int INV2 = (M + 1) / 2;           // inverse of 2 modulo odd M
      int s, x, t;
      logic [W-1:0] f;

      always_comb begin
         s = int'(pa_i[LO +: W]) + int'(pb_i[LO +: W]);
         x = int'(aux_i[LO +: W]);
         unique case (op_i)
            OP_ADD:  t = (s + M - (carry_i ? WRAP : 0)) % M;
            OP_AND:  t = (((s + 2 * M - x) % M) * INV2) % M;
            OP_OR:   t = (((s + x) % M) * INV2) % M;
            default: t = (s + 2 * M - ((2 * x) % M)) % M;
         endcase
         f = W'(t);
      end

      assign res_o[LO +: W] = f;
   end
endmodule

// File: rtl/resid_alu.sv
`timescale 1ns/1ps
module resid_alu import rmalu_pkg::*; #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [RES_W-1:0]  a_res_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [RES_W-1:0]  b_res_i,
   output logic [DATA_W-1:0] y_o,
   output logic [RES_W-1:0]  y_res_o,
   output logic              busy_o,
   output logic              res_ok_o
);
   if (DATA_W < 8) begin : g_bad_width
      $error("resid_alu: DATA_W must be at least 8");
   end
   for (genvar i = 0; i < NMOD; i++) begin : g_mod_chk
      if ((MODS[i] % 2) == 0 || MODS[i] < 3) begin : g_bad_mod
         $error("resid_alu: every modulus must be odd and at least 3");
      end
   end

   phase_e            phase;
   op_e               op_in, op_q, pred_op;
   logic [DATA_W-1:0] a_q, y_q, y_w, aux_w, enc_val;
   logic [RES_W-1:0]  a_res_q, b_res_q, aux_res_q, pred_q;
   logic [RES_W-1:0]  pred_pa, pred_pb, pred_w, enc_w;
   logic              carry_w, pred_carry, chk_q, enc_match;

   assign op_in  = op_e'(op_i);
   assign busy_o = (phase != PH_IDLE);

   rmalu_logic #(.DATA_W(DATA_W)) u_logic (
      .a_i(a_i), .b_i(b_i), .op_i(op_in),
      .y_o(y_w), .aux_o(aux_w), .carry_o(carry_w)
   );

   // idle: predict straight from the ports (add); later: from latched copies
   always_comb begin
      if (phase == PH_IDLE) begin
         pred_op = op_in; pred_pa = a_res_i; pred_pb = b_res_i; pred_carry = carry_w;
      end else begin
         pred_op = op_q;  pred_pa = a_res_q; pred_pb = b_res_q; pred_carry = 1'b0;
      end
   end

   rmalu_predict #(.DATA_W(DATA_W)) u_predict (
      .op_i(pred_op), .pa_i(pred_pa), .pb_i(pred_pb),
      .aux_i(aux_res_q), .carry_i(pred_carry), .res_o(pred_w)
   );

   // the single encoder: helper word, then result, then operand A
   always_comb begin
      unique case (phase)
         PH_IDLE: enc_val = (op_in == OP_ADD) ? y_w : aux_w;
         PH_RES:  enc_val = y_q;
         default: enc_val = a_q;
      endcase
   end

   rmalu_encoder #(.DATA_W(DATA_W)) u_enc (.val_i(enc_val), .res_o(enc_w));

   assign enc_match = (enc_w == pred_w);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         op_q      <= OP_ADD;
         a_q       <= '0;
         y_q       <= '0;
         a_res_q   <= '0;
         b_res_q   <= '0;
         aux_res_q <= '0;
         pred_q    <= '0;
         chk_q     <= 1'b0;
         y_o       <= '0;
         y_res_o   <= '0;
         res_ok_o  <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start_i) begin
                  if (op_in == OP_ADD) begin
                     y_o      <= y_w;
                     y_res_o  <= pred_w;
                     res_ok_o <= enc_match;
                  end else begin
                     phase     <= PH_RES;
                     op_q      <= op_in;
                     a_q       <= a_i;
                     y_q       <= y_w;
                     a_res_q   <= a_res_i;
                     b_res_q   <= b_res_i;
                     aux_res_q <= enc_w;
                  end
               end
            end
            PH_RES: begin
               pred_q <= pred_w;
               chk_q  <= enc_match;
               phase  <= PH_OPD;
            end
            default: begin
               y_o      <= y_q;
               y_res_o  <= pred_q;
               res_ok_o <= chk_q && (enc_w == a_res_q);
               phase    <= PH_IDLE;
            end
         endcase
      end
   end

   // R7: Boolean sequence keeps busy for exactly two cycles
   p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |=> busy_o ##1 !busy_o);

   // R7: outputs frozen while the sequence is mid-way
   p_hold_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && phase == PH_RES) |=> $stable(y_o) && $stable(y_res_o) && $stable(res_ok_o));

   // R2: add completes at the sampling edge without raising busy
   p_add_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_i == 2'd0) |=> !busy_o && (y_o == $past(a_i + b_i)));

   // R8: a start seen while busy leaves the captured operation untouched
   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> $stable(a_q) && $stable(op_q) && $stable(a_res_q));

   for (genvar i = 0; i < NMOD; i++) begin : g_out_chk
      localparam int M  = MODS[i];
      localparam int W  = fld_w(i);
      localparam int LO = fld_lo(i);
      // R1: every field of the emitted check vector is a reduced residue
      p_field_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
         y_res_o[LO +: W] < W'(M));
   end
endmodule

// File: tb/resid_alu_test.sv
`timescale 1ns/1ps
module resid_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [31:0] a = '0, b = '0;
   logic [15:0] pa = '0, pb = '0;
   logic [31:0] y;
   logic [15:0] yr;
   logic        busy, ok;

   int    n_chk = 0, n_bad = 0, cyc = 0;
   string cur_req = "R11";

   resid_alu uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
      .a_i(a), .a_res_i(pa), .b_i(b), .b_res_i(pb),
      .y_o(y), .y_res_o(yr), .busy_o(busy), .res_ok_o(ok)
   );

   always #2.5 clk = ~clk;

   int mods [4] = '{5, 7, 17, 31};

   function automatic int fld(logic [15:0] v, int i);
      case (i)
         0: return int'(v[2:0]);
         1: return int'(v[5:3]);
         2: return int'(v[10:6]);
         default: return int'(v[15:11]);
      endcase
   endfunction

   function automatic logic [15:0] pack(int r0, int r1, int r2, int r3);
      return {5'(r3), 5'(r2), 3'(r1), 3'(r0)};
   endfunction

   function automatic logic [15:0] enc(logic [31:0] x);
      return pack(int'(x % 5), int'(x % 7), int'(x % 17), int'(x % 31));
   endfunction

   function automatic int half(int s, int m);
      for (int x = 0; x < m; x++) if (((2 * x) % m) == s) return x;
      return 0;
   endfunction

   function automatic int pos_mod(int v, int m);
      return ((v % m) + m) % m;
   endfunction

   function automatic logic [15:0] predict(int o, logic [31:0] da, logic [31:0] db,
                                           logic [15:0] ra, logic [15:0] rb);
      int r [4];
      longint unsigned sum;
      sum = longint'(da) + longint'(db);
      for (int i = 0; i < 4; i++) begin
         int m, s, k;
         m = mods[i];
         s = fld(ra, i) + fld(rb, i);
         case (o)
            0: begin
               k = int'((64'd1 << 32) % m);
               r[i] = pos_mod(s - int'(sum >> 32) * k, m);
            end
            1: r[i] = half(pos_mod(s - int'((da ^ db) % m), m), m);
            2: r[i] = half(pos_mod(s + int'((da ^ db) % m), m), m);
            default: r[i] = pos_mod(s - 2 * int'((da & db) % m), m);
         endcase
      end
      return pack(r[0], r[1], r[2], r[3]);
   endfunction

   function automatic logic [31:0] compute(int o, logic [31:0] da, logic [31:0] db);
      case (o)
         0: return da + db;
         1: return da & db;
         2: return da | db;
         default: return da ^ db;
      endcase
   endfunction

   // behavioural reference, stepped on each rising edge
   int          cnt = 0;
   logic [31:0] e_y = '0, p_y = '0;
   logic [15:0] e_r = '0, p_r = '0;
   logic        e_ok = 1'b0, p_ok = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         cnt = 0; e_y = '0; e_r = '0; e_ok = 1'b0;
      end else if (cnt > 0) begin
         cnt = cnt - 1;
         if (cnt == 0) begin
            e_y = p_y; e_r = p_r; e_ok = p_ok;
         end
      end else if (start) begin
         p_y  = compute(int'(op), a, b);
         p_r  = predict(int'(op), a, b, pa, pb);
         p_ok = (enc(p_y) == p_r) && ((op == 2'd0) || (enc(a) == pa));
         if (op == 2'd0) begin
            e_y = p_y; e_r = p_r; e_ok = p_ok;
         end else begin
            cnt = 2;
         end
      end
   end

   always @(negedge clk) begin
      n_chk++;
      if (y !== e_y) begin
         n_bad++; $display("FAIL %s y_o actual %h expected %h", cur_req, y, e_y);
      end
      n_chk++;
      if (yr !== e_r) begin
         n_bad++; $display("FAIL %s y_res_o actual %h expected %h", cur_req, yr, e_r);
      end
      n_chk++;
      if (busy !== (cnt != 0)) begin
         n_bad++; $display("FAIL %s busy_o actual %b expected %b", cur_req, busy, cnt != 0);
      end
      n_chk++;
      if (ok !== e_ok) begin
         n_bad++; $display("FAIL %s res_ok_o actual %b expected %b", cur_req, ok, e_ok);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL %s watchdog actual %0d cycles expected below 20000", cur_req, cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic issue(int o, logic [31:0] da, logic [31:0] db,
                        logic [15:0] ra, logic [15:0] rb, int hold);
      @(negedge clk);
      start = 1'b1; op = 2'(o); a = da; b = db; pa = ra; pb = rb;
      for (int h = 1; h < hold; h++) begin
         @(negedge clk);
         op = 2'(3 - o); a = ~da; b = db + 32'd7; pa = enc(~da); pb = enc(db + 32'd7);
      end
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic clean(int o, logic [31:0] da, logic [31:0] db);
      issue(o, da, db, enc(da), enc(db), 1);
   endtask

   initial begin
      logic [15:0] ra, rb;
      cur_req = "R11";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R12";
      repeat (2) @(negedge clk);

      cur_req = "R2";
      clean(0, 32'd1234, 32'd4321);
      clean(0, 32'h0000_0000, 32'h0000_0000);
      cur_req = "R1";
      clean(0, 32'h1234_5678, 32'h0FED_CBA9);
      cur_req = "R3";
      clean(0, 32'hFFFF_FFF0, 32'h0000_0025);
      clean(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

      cur_req = "R4";
      clean(1, 32'hF0F0_F0F0, 32'h3C3C_3C3C);
      clean(1, 32'hFFFF_FFFF, 32'h8000_0001);
      cur_req = "R5";
      clean(2, 32'h0000_00FF, 32'hFF00_0000);
      clean(2, 32'hDEAD_BEEF, 32'h1357_9BDF);
      cur_req = "R6";
      clean(3, 32'hAAAA_AAAA, 32'h5555_5555);
      clean(3, 32'hCAFE_F00D, 32'hCAFE_F00D);

      cur_req = "R7";
      clean(1, 32'h0123_4567, 32'h89AB_CDEF);

      cur_req = "R8";
      issue(2, 32'h0F0F_0000, 32'h00F0_0F00, enc(32'h0F0F_0000), enc(32'h00F0_0F00), 3);
      issue(3, 32'h7777_1111, 32'h2222_9999, enc(32'h7777_1111), enc(32'h2222_9999), 2);

      cur_req = "R9";
      ra = enc(32'd1000); ra[5:3] = 3'((fld(ra, 1) + 1) % 7);
      issue(0, 32'd1000, 32'd2000, ra, enc(32'd2000), 1);
      rb = enc(32'h5A5A_0000); rb[15:11] = 5'((fld(rb, 3) + 3) % 31);
      issue(3, 32'h1111_2222, 32'h5A5A_0000, enc(32'h1111_2222), rb, 1);

      cur_req = "R10";
      ra = enc(32'hBEEF_0001); rb = enc(32'h0BAD_F00D);
      ra[2:0] = 3'((fld(ra, 0) + 1) % 5);
      rb[2:0] = 3'((fld(rb, 0) + 4) % 5);
      issue(1, 32'hBEEF_0001, 32'h0BAD_F00D, ra, rb, 1);
      issue(2, 32'hBEEF_0001, 32'h0BAD_F00D, ra, rb, 1);

      cur_req = "R1";
      for (int n = 0; n < 40; n++) begin
         clean(n % 4, $urandom, $urandom);
      end

      cur_req = "R12";
      repeat (5) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule